// File: doc/BRIEF.md
# Microcoded 4-bit Accumulator Processor

This block is a small stored-program machine with a 4-bit word. Program and data share one 16-entry memory of 4-bit words. The memory is filled through a preload port while the core is held in reset. After reset is released, the core fetches an instruction nibble, decodes it and runs a short microstep sequence. When the instruction is done, the sequence returns to the fetch step.

The machine is built around an accumulator. Two-nibble instructions take a second nibble. For jumps, that nibble is the target. For loads and ALU operations, it is the address of the operand, so the operand needs one more memory read. A separate swap register can be exchanged with the accumulator. It can also serve as the second adder operand. The only condition flag is an overflow flag, set by carry or borrow. The accumulator leaves the block on a 4-bit output port, together with a one-cycle valid strobe.

Top module: `acc4_core`

## Requirements
- R1: Synchronous reset clears the program counter, accumulator, swap register, operand register, overflow flag and output port, and puts the sequencer at its first step. Memory contents are kept through reset, and memory is written from the preload port while reset is held.
- R2: Each instruction starts by reading the nibble at the program counter as its opcode and advancing the program counter by one. The program counter wraps from 15 to 0, including while an operand nibble is being read.
- R3: Opcodes 0x0, 0x7 and 0x8 occupy one nibble and change no register except the program counter step of the fetch.
- R4: Opcode 0x4 takes the next nibble as an address and loads the memory word at that address into the accumulator. Execution continues after the operand nibble.
- R5: Opcodes 0x9, 0xA and 0xB read the word at the operand address into the operand register and replace the accumulator with NAND, NOR or XOR of the accumulator and that word. Opcode 0x6 (one nibble) replaces the accumulator with its bitwise complement.
- R6: Opcode 0xC adds, and 0xD subtracts, the word at the operand address to or from the accumulator, modulo 16. The overflow flag becomes the carry-out of the add, or the borrow of the subtract (accumulator smaller than operand).
- R7: Opcodes 0xE and 0xF (one nibble) take the swap register as the second operand, and add or subtract it with the same flag rule as R6.
- R8: Opcode 0x5 (one nibble) exchanges the accumulator and the swap register in a single step.
- R9: Opcode 0x1 loads the program counter with the operand nibble. Opcode 0x2 does the same only when the overflow flag is set, and otherwise continues after the operand nibble.
- R10: The overflow flag changes only on opcodes 0xC, 0xD, 0xE and 0xF. Logic, load, swap and jump instructions keep it.
- R11: Opcode 0x3 (one nibble) drives the accumulator onto the output port and raises the valid strobe for exactly one cycle per execution.
- R12: The image 4,F,3,C,E,2,0,1,2,0,0,0,0,0,1,0 (address 0 first) outputs the stream 0,1,…,15 and then repeats from 0.
- R13: The image 4,F,5,4,F,3,E,2,0,3,5,1,6,0,0,1 repeatedly outputs 1,2,3,5,8,13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Writes loadData into memory at loadAddr |
| loadAddr | input | 4 | Preload address |
| loadData | input | 4 | Preload word |
| outData | output | 4 | Accumulator value captured by the output opcode |
| outValid | output | 1 | One-cycle strobe marking a new outData |

## Verification
The assertions assume that memory is written only while reset is held, so the program image cannot change under a running sequence. They also assume that the preload port carries no traffic once the core runs. Every bench scenario loads its whole image during reset and drops the load enable before releasing reset. The directed images are built so that each one exercises its intended opcodes while the remaining nibbles still decode to legal behaviour. One image, for example, deliberately executes data words and wraps the program counter through an operand read.

// File: rtl/acc4_pkg.sv
package acc4_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_JMP  = 4'h1, OP_JPO  = 4'h2, OP_OUT  = 4'h3,
    OP_LDA  = 4'h4, OP_SWP  = 4'h5, OP_INV  = 4'h6, OP_JMZ  = 4'h7,
    OP_JME  = 4'h8, OP_NAND = 4'h9, OP_NOR  = 4'hA, OP_XOR  = 4'hB,
    OP_ADD  = 4'hC, OP_SUB  = 4'hD, OP_ADS  = 4'hE, OP_SBS  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_ADDR  = 3'd0,
    ST_FETCH = 3'd1,
    ST_EXEC  = 3'd2,
    ST_OPND  = 3'd3,
    ST_PTR   = 3'd4,
    ST_ALU   = 3'd5
  } step_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_NAND = 3'd2,
    ALU_NOR  = 3'd3,
    ALU_XOR  = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    marFromPc;
    logic    marFromMem;
    logic    irLoad;
    logic    pcInc;
    logic    pcLoad;
    logic    accLoadMem;
    logic    accLoadAlu;
    logic    accInv;
    logic    swapEx;
    logic    bFromMem;
    logic    bFromSwp;
    logic    ovfWr;
    logic    outLoad;
    alu_op_e aluOp;
  } ctrl_strobe_t;

endpackage

// File: rtl/acc4_alu.sv
module acc4_alu
  import acc4_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  alu_op_e           aluOp,
  output logic [WORD_W-1:0] result,
  output logic              carryOut
);

  logic [WORD_W:0] wide;

  always_comb begin
    case (aluOp)
      ALU_ADD:  wide = {1'b0, opA} + {1'b0, opB};
      ALU_SUB:  wide = {1'b0, opA} - {1'b0, opB};
      ALU_NAND: wide = {1'b0, ~(opA & opB)};
      ALU_NOR:  wide = {1'b0, ~(opA | opB)};
      ALU_XOR:  wide = {1'b0, opA ^ opB};
      default:  wide = '0;
    endcase
  end

  assign result   = wide[WORD_W-1:0];
  assign carryOut = wide[WORD_W];

endmodule

// File: rtl/acc4_ctrl.sv
module acc4_ctrl
  import acc4_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   opBits,
  input  logic         ovfFlag,
  output ctrl_strobe_t cs,
  output step_e        step
);

  opcode_e op;
  step_e   nextStep;
  logic    isArith;

  assign op      = opcode_e'(opBits);
  assign isArith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADS) || (op == OP_SBS);

  always_ff @(posedge clk) begin
    if (rst) step <= ST_ADDR;
    else     step <= nextStep;
  end

  always_comb begin
    cs       = '0;
    nextStep = ST_ADDR;
    case (step)
      ST_ADDR: begin
        cs.marFromPc = 1'b1;
        nextStep     = ST_FETCH;
      end
      ST_FETCH: begin
        cs.irLoad = 1'b1;
        cs.pcInc  = 1'b1;
        nextStep  = ST_EXEC;
      end
      ST_EXEC: begin
        case (op)
          OP_NOP, OP_JMZ, OP_JME: nextStep = ST_ADDR;
          OP_OUT: cs.outLoad = 1'b1;
          OP_SWP: cs.swapEx  = 1'b1;
          OP_INV: cs.accInv  = 1'b1;
          OP_ADS, OP_SBS: begin
            cs.bFromSwp = 1'b1;
            nextStep    = ST_ALU;
          end
          default: begin
            cs.marFromPc = 1'b1;
            nextStep     = ST_OPND;
          end
        endcase
      end
      ST_OPND: begin
        case (op)
          OP_JMP: cs.pcLoad = 1'b1;
          OP_JPO: begin
            cs.pcLoad = ovfFlag;
            cs.pcInc  = !ovfFlag;
          end
          default: begin
            cs.marFromMem = 1'b1;
            cs.pcInc      = 1'b1;
            nextStep      = ST_PTR;
          end
        endcase
      end
      ST_PTR: begin
        if (op == OP_LDA) begin
          cs.accLoadMem = 1'b1;
        end else begin
          cs.bFromMem = 1'b1;
          nextStep    = ST_ALU;
        end
      end
      ST_ALU: begin
        cs.accLoadAlu = 1'b1;
        cs.ovfWr      = isArith;
        case (op)
          OP_NAND:        cs.aluOp = ALU_NAND;
          OP_NOR:         cs.aluOp = ALU_NOR;
          OP_XOR:         cs.aluOp = ALU_XOR;
          OP_SUB, OP_SBS: cs.aluOp = ALU_SUB;
          default:        cs.aluOp = ALU_ADD;
        endcase
      end
      default: nextStep = ST_ADDR;
    endcase
  end

endmodule

// File: rtl/acc4_datapath.sv
module acc4_datapath
  import acc4_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  ctrl_strobe_t      cs,
  output logic [WORD_W-1:0] irVal,
  output logic              ovfVal,
  output logic [WORD_W-1:0] pcVal,
  output logic [WORD_W-1:0] accVal,
  output logic [WORD_W-1:0] swpVal,
  output logic [WORD_W-1:0] outData,
  output logic              outValid
);

  localparam int DEPTH = 1 << WORD_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mar;
  logic [WORD_W-1:0] bReg;
  logic [WORD_W-1:0] memRd;
  logic [WORD_W-1:0] aluRes;
  logic              aluCarry;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (loadEn && loadAddr == WORD_W'(i)) mem[i] <= loadData;
    end
  end

  assign memRd = mem[mar];

  acc4_alu #(.WORD_W(WORD_W)) u_alu (
    .opA      (accVal),
    .opB      (bReg),
    .aluOp    (cs.aluOp),
    .result   (aluRes),
    .carryOut (aluCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcVal    <= '0;
      mar      <= '0;
      irVal    <= '0;
      accVal   <= '0;
      swpVal   <= '0;
      bReg     <= '0;
      ovfVal   <= 1'b0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (cs.marFromPc)       mar <= pcVal;
      else if (cs.marFromMem) mar <= memRd;

      if (cs.irLoad) irVal <= memRd;

      if (cs.pcLoad)     pcVal <= memRd;
      else if (cs.pcInc) pcVal <= pcVal + WORD_W'(1);

      if (cs.accLoadMem)      accVal <= memRd;
      else if (cs.accLoadAlu) accVal <= aluRes;
      else if (cs.accInv)     accVal <= ~accVal;
      else if (cs.swapEx)     accVal <= swpVal;

      if (cs.swapEx) swpVal <= accVal;

      if (cs.bFromMem)      bReg <= memRd;
      else if (cs.bFromSwp) bReg <= swpVal;

      if (cs.ovfWr) ovfVal <= aluCarry;

      outValid <= cs.outLoad;
      if (cs.outLoad) outData <= accVal;
    end
  end

endmodule

// File: rtl/acc4_core.sv
module acc4_core
  import acc4_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] outData,
  output logic              outValid
);

  ctrl_strobe_t      cs;
  step_e             step;
  logic [WORD_W-1:0] irVal;
  logic [WORD_W-1:0] pcVal;
  logic [WORD_W-1:0] accVal;
  logic [WORD_W-1:0] swpVal;
  logic              ovfVal;

  acc4_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opBits  (irVal[3:0]),
    .ovfFlag (ovfVal),
    .cs      (cs),
    .step    (step)
  );

  acc4_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .cs       (cs),
    .irVal    (irVal),
    .ovfVal   (ovfVal),
    .pcVal    (pcVal),
    .accVal   (accVal),
    .swpVal   (swpVal),
    .outData  (outData),
    .outValid (outValid)
  );

endmodule

// File: rtl/acc4_core_chk.sv
module acc4_core_chk
  import acc4_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              outValid,
  input logic [WORD_W-1:0] outData,
  input logic [WORD_W-1:0] pc,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] swp,
  input logic [WORD_W-1:0] ir,
  input logic              ovf,
  input step_e             step,
  input ctrl_strobe_t      cs
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pc == '0 && acc == '0 && !outValid && step == ST_ADDR)); // R1
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst) (step == ST_FETCH) |=> (step == ST_EXEC && pc == $past(pc) + WORD_W'(1))); // R2
  AST_SINGLE_NIBBLE: assert property (@(posedge clk) disable iff (rst) (step == ST_EXEC && (ir == OP_NOP || ir == OP_JMZ || ir == OP_JME)) |=> (step == ST_ADDR && $stable(acc))); // R3
  AST_INVERT: assert property (@(posedge clk) disable iff (rst) (step == ST_EXEC && ir == OP_INV) |=> (acc == ~$past(acc))); // R5
  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (rst) cs.swapEx |=> (acc == $past(swp) && swp == $past(acc))); // R8
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst) !cs.ovfWr |=> $stable(ovf)); // R10
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst) outValid |=> !outValid); // R11
  AST_OUT_VALUE: assert property (@(posedge clk) disable iff (rst) outValid |-> (outData == $past(acc))); // R11

endmodule

bind acc4_core acc4_core_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .outValid (outValid),
  .outData  (outData),
  .pc       (pcVal),
  .acc      (accVal),
  .swp      (swpVal),
  .ir       (irVal),
  .ovf      (ovfVal),
  .step     (step),
  .cs       (cs)
);

// File: tb/tb_acc4_core.sv
module tb_acc4_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [3:0] loadAddr = '0;
  logic [3:0] loadData = '0;
  logic [3:0] outData;
  logic       outValid;

  int nChecks = 0;
  int nFail = 0;
  int capCount = 0;
  int widthErr = 0;
  logic prevValid = 1'b0;
  logic [3:0] captured [64];

  always #5 clk = ~clk;

  acc4_core dut (
    .clk      (clk),
    .rst      (rst),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .outData  (outData),
    .outValid (outValid)
  );

  always @(negedge clk) begin
    if (rst) begin
      capCount  = 0;
      widthErr  = 0;
      prevValid = 1'b0;
    end else begin
      if (outValid) begin
        if (capCount < 64) captured[capCount] = outData;
        capCount++;
        if (prevValid) widthErr++;
      end
      prevValid = outValid;
    end
  end

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // image: address 0 in the most significant nibble
  task automatic loadProg(input logic [63:0] img);
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      loadEn   = 1'b1;
      loadAddr = i[3:0];
      loadData = img[63-4*i -: 4];
      @(negedge clk);
    end
    loadEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic waitOut(input string req, input int n);
    int cyc = 0;
    while (capCount < n && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    checkVal(req, "output count reached", capCount >= n ? 1 : 0, 1);
  endtask

  task automatic checkStream(input string req, input int n, input logic [63:0] expv);
    for (int i = 0; i < n; i++)
      checkVal(req, $sformatf("output %0d", i), int'(captured[i]), int'(expv[63-4*i -: 4]));
  endtask

  task automatic testResetState();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkVal("R1", "outValid in reset", int'(outValid), 0);
    checkVal("R1", "outData in reset", int'(outData), 0);
  endtask

  task automatic testCounter();
    loadProg(64'h4F3CE20120000010);
    waitOut("R12", 34);
    for (int i = 0; i < 34; i++)
      checkVal("R12", $sformatf("counter output %0d", i), int'(captured[i]), i % 16);
    checkVal("R11", "strobe width errors", widthErr, 0);
  endtask

  task automatic testResetClears();
    // OUT, JMP 0: accumulator must read zero after reset
    loadProg(64'h3100000000000000);
    waitOut("R1", 2);
    checkVal("R1", "acc after reset", int'(captured[0]), 0);
    checkVal("R1", "acc after reset, second", int'(captured[1]), 0);
  endtask

  task automatic testFib();
    int seq [6] = '{1, 2, 3, 5, 8, 13};
    loadProg(64'h4F54F3E203516001);
    waitOut("R13", 14);
    for (int i = 0; i < 14; i++)
      checkVal("R13", $sformatf("fib output %0d", i), int'(captured[i]), seq[i % 6]);
  endtask

  task automatic testLogic();
    // acc=C, NAND A ->7, XOR A ->D, INV ->2, NOR A ->5
    loadProg(64'h4E9F3BF363AF30CA);
    waitOut("R5", 4);
    checkStream("R5", 4, 64'h7D25000000000000);
    checkVal("R4", "load from operand address", int'(captured[0]), 7);
  endtask

  task automatic testSubJump();
    // 3-5 borrow -> JPO taken; E-5 no borrow -> JPO falls through; wrap
    loadProg(64'h4EDF28303DF20335);
    waitOut("R6", 6);
    checkStream("R6", 3, 64'hE990000000000000);
    checkVal("R9", "taken JPO skips OUT at 6", int'(captured[0]), 14);
    checkVal("R2", "after wrap, first output", int'(captured[3]), 14);
    checkVal("R2", "after wrap, second output", int'(captured[4]), 9);
  endtask

  task automatic testSingleNibble();
    // JMZ/JME/NOP, ADD carry, SBS borrow, ADS carry, wrap inside operand read
    loadProg(64'h4F780CF32B35F3E9);
    waitOut("R3", 3);
    checkVal("R6", "ADD carry result", int'(captured[0]), 2);
    checkVal("R7", "SBS with swap", int'(captured[1]), 14);
    checkVal("R3", "NI opcodes single nibble", int'(captured[2]), 6);
    checkVal("R8", "swap feeds SBS", int'(captured[1]), 14);
  endtask

  task automatic testOvfHold();
    // F+F carry, XOR keeps flag, JPO 9 taken skips INV
    loadProg(64'h4ECEBE29631A00F0);
    waitOut("R10", 1);
    checkVal("R10", "flag kept across XOR", int'(captured[0]), 1);
    repeat (80) @(negedge clk);
    checkVal("R11", "exactly one output", capCount, 1);
    checkVal("R9", "JMP loops without output", capCount, 1);
    checkVal("R11", "strobe width errors", widthErr, 0);
  endtask

  initial begin
    testResetState();
    testCounter();
    testResetClears();
    testFib();
    testLogic();
    testSubJump();
    testSingleNibble();
    testOvfHold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule